// File: doc/BRIEF.md
# Cascaded Interrupt Controller with DMA Halt

This block gathers the interrupt requests of a peripheral I/O chip and presents them to a processor as one level-sensitive request line. It has two kinds of source lines. Peripheral lines sit at the low indices and are level sources: their status bits copy the request inputs every cycle. DMA lines sit above a fixed boundary index and are event sources: a one-cycle pulse latches the status bit, and the bit stays set until software clears it.

Each DMA line belongs to one of two classes, set by a constant class parameter. A set bit in that parameter marks an informational line; a clear bit marks an error line. A pending informational event leaves its DMA channel running. A pending error event drops that channel's run enable, and the enable stays low until software clears the status bit. Software reaches the block through a small register port that holds a mask register and a status register. Status bits are cleared by writing a zero to them.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the mask register reads 0, every DMA status bit is 0, `cpu_irq` is 0 and `dma_run` is all ones.
- R2: A write with `reg_addr` = 0 loads the mask register from `reg_wdata`. A mask bit of 1 lets that line reach `cpu_irq` and a 0 blocks it.
- R3: Status bits 0 to 23 (the peripheral lines) take the value of `periph_req` at each clock edge, and writes to the status register leave them unchanged.
- R4: A write with `reg_addr` = 1 clears DMA status bit i (status bit 24+i) when `reg_wdata` bit 24+i is 0. The bit keeps its value when the written bit is 1. With no event and no write, DMA status bits hold.
- R5: A pulse on `dma_evt[i]` sets status bit 24+i at the next edge, even when a clear of that bit is written in the same cycle.
- R6: While the status bit of an error-class DMA line i is set (class parameter bit i = 0, which is lines 2, 3 and 6 by default), `dma_run[i]` is 0. It returns to 1 in the cycle after the clear write. Informational lines (bits 0, 1, 4, 5 and 7) never lower `dma_run`.
- R7: `cpu_irq` is a register. It equals the OR over all bits of (status AND mask) as they stood one clock edge earlier, so it changes one cycle after either register changes.
- R8: A read with `reg_addr` 0 returns the mask and a read with `reg_addr` 1 returns the status. `reg_rdata` carries the value the register held in the cycle `reg_rd` was high, and `reg_rvalid` is 1 in the following cycle.
- R9: An informational DMA line can be latched again by an event in the cycle right after its clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register select: 0 = mask, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |
| periph_req | input | 24 | Level requests from the peripheral lines |
| dma_evt | input | 8 | One-cycle DMA event pulses |
| dma_run | output | 8 | Run enable for each DMA channel |
| cpu_irq | output | 1 | Level interrupt request to the processor |

## Verification
A DMA status bit stuck at the wrong value shows at `dma_run` in the very next cycle for error lines. For every line it shows at `cpu_irq` one cycle later, provided the line is unmasked. The run enables are therefore sampled right after each event and each clear, and `cpu_irq` is sampled in both the cycle before and the cycle after its expected change. A corrupted mask, a clear applied to the wrong bits, or a lost set-over-clear race is seen on the read port within two cycles of the status read that follows.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register select carried on reg_addr
  typedef enum logic {
    SEL_MASK   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int NUM_PERIPH = 24,
  parameter int NUM_DMA    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic                           reg_addr,
  input  logic [REG_W-1:0]               reg_wdata,
  input  logic [NUM_PERIPH+NUM_DMA-1:0]  status_q,
  output logic [NUM_PERIPH+NUM_DMA-1:0]  mask_q,
  output logic                           clr_strobe,
  output logic [NUM_DMA-1:0]             clr_keep,
  output logic [REG_W-1:0]               reg_rdata,
  output logic                           reg_rvalid
);
  localparam int LINES = NUM_PERIPH + NUM_DMA;

  reg_sel_e sel;
  logic     wr_mask;

  function automatic logic [REG_W-1:0] widen(input logic [LINES-1:0] v);
    return REG_W'(v);
  endfunction

  assign sel        = reg_sel_e'(reg_addr);
  assign wr_mask    = reg_wr && (sel == SEL_MASK);
  assign clr_strobe = reg_wr && (sel == SEL_STATUS);
  assign clr_keep   = reg_wdata[LINES-1:NUM_PERIPH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= reg_wdata[LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        reg_rdata <= (sel == SEL_MASK) ? widen(mask_q) : widen(status_q);
      end
    end
  end

  // R8: a read strobe yields valid data one cycle later, and only then
  p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_no_spurious_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
  // R2: a mask write lands in the mask register at the next edge
  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata[LINES-1:0])));
  // R1: the mask is empty in the first cycle after reset
  p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0));
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int NUM_PERIPH = 24,
  parameter int NUM_DMA    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PERIPH-1:0]          periph_req,
  input  logic [NUM_DMA-1:0]             dma_evt,
  input  logic                           clr_strobe,
  input  logic [NUM_DMA-1:0]             clr_keep,
  output logic [NUM_PERIPH+NUM_DMA-1:0]  status_q
);
  localparam int LINES = NUM_PERIPH + NUM_DMA;

  logic [NUM_DMA-1:0] status_dma;

  // Latched event bit: a new event wins over a clear in the same cycle
  function automatic logic next_event_bit(input logic cur, input logic clr_en,
                                          input logic keep, input logic evt);
    return evt | (cur & ~(clr_en & ~keep));
  endfunction

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic bit_q;
    if (g < NUM_PERIPH) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= periph_req[g];
      end
    end else begin : g_event
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= next_event_bit(bit_q, clr_strobe,
                                            clr_keep[g-NUM_PERIPH],
                                            dma_evt[g-NUM_PERIPH]);
      end
    end
    assign status_q[g] = bit_q;
  end

  assign status_dma = status_q[LINES-1:NUM_PERIPH];

  // R3: peripheral bits copy the request inputs one edge later
  p_periph_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_q[NUM_PERIPH-1:0] == $past(periph_req)));
  // R5: every pulsed event is pending after the next edge
  p_evt_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt != '0) |=> ((status_dma & $past(dma_evt)) == $past(dma_evt)));
  // R4: with no event and no write, DMA bits hold
  p_dma_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_strobe && dma_evt == '0) |=> $stable(status_dma));
  // R4: bits written as zero are clear after the write when no event came
  p_dma_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && dma_evt == '0) |=> ((status_dma & ~$past(clr_keep)) == '0));
endmodule

// File: rtl/irqc_dma_gate.sv
module irqc_dma_gate #(
  parameter int                 NUM_DMA    = 8,
  parameter logic [NUM_DMA-1:0] INFO_CLASS = 8'hB3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] dma_evt,
  input  logic [NUM_DMA-1:0] status_dma,
  output logic [NUM_DMA-1:0] dma_run
);
  localparam logic [NUM_DMA-1:0] ERR_CLASS = ~INFO_CLASS;

  // Channels held by a pending error-class event
  function automatic logic [NUM_DMA-1:0] halt_bits(input logic [NUM_DMA-1:0] st);
    return st & ERR_CLASS;
  endfunction

  logic [NUM_DMA-1:0] halted;

  assign halted  = halt_bits(status_dma);
  assign dma_run = ~halted;

  // R6: an error event stops its channel from the next cycle
  p_err_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_evt & ERR_CLASS) != '0) |=> ((dma_run & $past(dma_evt & ERR_CLASS)) == '0));
  // R6: an informational event leaves its channel running
  p_info_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_evt & INFO_CLASS) != '0) |=> ((dma_run & $past(dma_evt & INFO_CLASS)) == $past(dma_evt & INFO_CLASS)));
endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] status_q,
  input  logic [LINES-1:0] mask_q,
  output logic             cpu_irq
);
  function automatic logic any_pending(input logic [LINES-1:0] st,
                                       input logic [LINES-1:0] mk);
    return |(st & mk);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= any_pending(status_q, mask_q);
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int                 NUM_PERIPH = 24,
  parameter int                 NUM_DMA    = 8,
  parameter logic [NUM_DMA-1:0] INFO_CLASS = 8'hB3,
  parameter int                 REG_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic                  reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  reg_rvalid,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [NUM_DMA-1:0]    dma_evt,
  output logic [NUM_DMA-1:0]    dma_run,
  output logic                  cpu_irq
);
  localparam int LINES = NUM_PERIPH + NUM_DMA;

  logic [LINES-1:0]   status_q;
  logic [LINES-1:0]   mask_q;
  logic               clr_strobe;
  logic [NUM_DMA-1:0] clr_keep;
  logic [NUM_DMA-1:0] status_dma;

  assign status_dma = status_q[LINES-1:NUM_PERIPH];

  irqc_regport #(
    .REG_W(REG_W), .NUM_PERIPH(NUM_PERIPH), .NUM_DMA(NUM_DMA)
  ) u_regport (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_q(status_q),
    .mask_q(mask_q), .clr_strobe(clr_strobe), .clr_keep(clr_keep),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  irqc_status #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_DMA(NUM_DMA)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .dma_evt(dma_evt),
    .clr_strobe(clr_strobe), .clr_keep(clr_keep), .status_q(status_q)
  );

  irqc_dma_gate #(
    .NUM_DMA(NUM_DMA), .INFO_CLASS(INFO_CLASS)
  ) u_dma_gate (
    .clk(clk), .rst_n(rst_n), .dma_evt(dma_evt),
    .status_dma(status_dma), .dma_run(dma_run)
  );

  irqc_irq_out #(
    .LINES(LINES)
  ) u_irq_out (
    .clk(clk), .rst_n(rst_n), .status_q(status_q), .mask_q(mask_q),
    .cpu_irq(cpu_irq)
  );

  // R7: the processor line follows the masked status one edge later
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cpu_irq == $past((status_q & mask_q) != '0)));
  // R1: no request and all channels running right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cpu_irq && dma_run == '1));
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;
  localparam logic [7:0] INFO = 8'hB3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [23:0] periph_req = '0;
  logic [7:0]  dma_evt = '0;
  logic [7:0]  dma_run;
  logic        cpu_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_cascade_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .periph_req(periph_req), .dma_evt(dma_evt),
    .dma_run(dma_run), .cpu_irq(cpu_irq)
  );

  // Bench's own view of the run enables for a DMA status pattern
  function automatic logic [7:0] run_of(input logic [7:0] dma_st);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = !(dma_st[i] && !INFO[i]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected word to the scoreboard
  task automatic rd(input logic a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Monitor: pop and compare as read data appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);
    chk("R1 dma_run after reset", {24'd0, dma_run}, 32'h0000_00FF);
    rd(1'b0, 32'h0, "R1 mask after reset");
    rd(1'b1, 32'h0, "R1 status after reset");

    // R3: peripheral bits mirror the inputs and ignore writes
    periph_req = 24'h5A3C0F;
    @(negedge clk);
    rd(1'b1, 32'h005A_3C0F, "R3 peripheral mirror");
    wr(1'b1, 32'h0);
    rd(1'b1, 32'h005A_3C0F, "R3 write ignored by peripheral bits");
    chk("R7 masked source gives no irq", {31'd0, cpu_irq}, 32'd0);

    // R2/R7: unmasking line 0 raises cpu_irq one cycle after the mask edge
    wr(1'b0, 32'h0000_0001);
    chk("R7 irq not yet after mask write", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk);
    chk("R7 irq after mask write", {31'd0, cpu_irq}, 32'd1);
    rd(1'b0, 32'h0000_0001, "R2 mask readback");

    // R3/R7: dropping the request lowers irq two edges later
    periph_req = '0;
    @(negedge clk);
    chk("R7 irq held one cycle", {31'd0, cpu_irq}, 32'd1);
    @(negedge clk);
    chk("R7 irq drops", {31'd0, cpu_irq}, 32'd0);

    // R6: error-class line 2 halts channel 2
    dma_evt = 8'h04;
    @(negedge clk);
    dma_evt = 8'h00;
    chk("R6 error event halts", {24'd0, dma_run}, {24'd0, run_of(8'h04)});
    repeat (3) @(negedge clk);
    chk("R6 halt persists", {24'd0, dma_run}, 32'h0000_00FB);
    rd(1'b1, 32'h0400_0000, "R4 event latched");

    // R4: writing ones keeps, writing zero clears
    wr(1'b1, 32'hFFFF_FFFF);
    chk("R4 write one keeps halt", {24'd0, dma_run}, 32'h0000_00FB);
    rd(1'b1, 32'h0400_0000, "R4 write one keeps bit");
    wr(1'b1, ~32'h0400_0000);
    chk("R6 clear releases channel", {24'd0, dma_run}, 32'h0000_00FF);
    rd(1'b1, 32'h0, "R4 write zero clears bit");

    // R6/R9: informational line 0 keeps running and re-arms at once
    dma_evt = 8'h01;
    @(negedge clk);
    dma_evt = 8'h00;
    chk("R6 info event keeps running", {24'd0, dma_run}, 32'h0000_00FF);
    rd(1'b1, 32'h0100_0000, "R6 info event latched");
    wr(1'b1, ~32'h0100_0000);
    dma_evt = 8'h01;
    rd(1'b1, 32'h0, "R9 cleared before re-arm");
    dma_evt = 8'h00;
    rd(1'b1, 32'h0100_0000, "R9 info re-armed right after clear");
    wr(1'b1, ~32'h0100_0000);

    // R5: event beats a same-cycle clear
    dma_evt = 8'h08;
    @(negedge clk);
    dma_evt = 8'h08;
    wr(1'b1, ~32'h0800_0000);
    dma_evt = 8'h00;
    chk("R5 set wins halt kept", {24'd0, dma_run}, 32'h0000_00F7);
    rd(1'b1, 32'h0800_0000, "R5 set wins over clear");
    wr(1'b1, ~32'h0800_0000);
    chk("R6 channel 3 released", {24'd0, dma_run}, 32'h0000_00FF);

    // R7: unmasked DMA line raises and lowers cpu_irq
    wr(1'b0, 32'h4000_0000);
    dma_evt = 8'h40;
    @(negedge clk);
    dma_evt = 8'h00;
    chk("R6 channel 6 halted", {24'd0, dma_run}, 32'h0000_00BF);
    chk("R7 dma irq not yet", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk);
    chk("R7 dma irq raised", {31'd0, cpu_irq}, 32'd1);
    wr(1'b1, ~32'h4000_0000);
    chk("R7 dma irq held after clear", {31'd0, cpu_irq}, 32'd1);
    @(negedge clk);
    chk("R7 dma irq dropped", {31'd0, cpu_irq}, 32'd0);

    // R2/R6: a masked error event still halts but raises no irq
    wr(1'b0, 32'h0);
    dma_evt = 8'h04;
    @(negedge clk);
    dma_evt = 8'h00;
    @(negedge clk);
    chk("R6 masked error still halts", {24'd0, dma_run}, 32'h0000_00FB);
    chk("R2 masked line no irq", {31'd0, cpu_irq}, 32'd0);
    wr(1'b1, 32'h0);
    rd(1'b1, 32'h0, "R4 full clear");
    rd(1'b0, 32'h0, "R8 mask read");

    repeat (3) @(negedge clk);
    chk("R8 all reads returned", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule